// File: doc/BRIEF.md
# Forced Output Compare Waveform Unit

This block is the compare and waveform stage that sits next to a 16-bit timer. Three channels each compare the running counter value against their own compare register. On a timer clock enable where the two are equal, the channel updates its waveform pin. The update follows that channel's 2-bit compare-output mode. The channel also raises a one-cycle match flag. In the clear-on-compare waveform mode, a match on channel A requests that the counter owner reset the count.

Software can also force a compare action on any channel. It does this by writing a control byte that carries one strobe per channel. A forced action changes only the waveform pin. It raises no match flag and never requests a counter clear. Forcing works only in the non-PWM waveform modes. The control byte always reads back as zero.

Top module: `ocf_wave_unit`

## Requirements
- R1: After reset, all waveform pins, all match flags and the counter clear request are 0.
- R2: The read data port always returns 8'h00, both before and after any control-byte write.
- R3: The force strobes sit in bit 7 (channel A), bit 6 (channel B) and bit 5 (channel C) of the control byte. A write with a strobe bit at 1 changes that channel's pin at the next clock edge. Bits 4 to 0 have no effect.
- R4: The pin action is set by the 2-bit mode: 2'b00 holds the pin, 2'b01 toggles it, 2'b10 drives it to 0, and 2'b11 drives it to 1. On the mode bus, channel A uses bits [1:0], channel B uses [3:2] and channel C uses [5:4].
- R5: Pins change only when the waveform mode is non-PWM, that is 4'd0, 4'd4 or 4'd12. In every other mode, strobes and matches leave all pins unchanged.
- R6: A forced action never sets a match flag.
- R7: A forced action never raises the counter clear request, including in waveform mode 4'd4.
- R8: A real match occurs when the timer clock enable is high and the counter equals the channel's compare value, in a non-PWM mode. It applies the same pin action as a force. It also sets that channel's match flag for exactly the one cycle after the match.
- R9: When the timer clock enable is low, an equal counter and compare value produce no flag and no pin change.
- R10: In mode 4'd4, a real match on channel A raises the clear request from the next cycle. The request holds until the edge of the next timer clock enable, which drops it. A match in mode 4'd0 raises no request.
- R11: A force and a real match on the same channel in the same cycle apply the pin action only once.
- R12: A forced action uses the compare-output mode present in the cycle of the write. A later change of mode does not alter the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_tick | input | 1 | Timer clock enable |
| tmr_count | input | 16 | Current counter value |
| wave_mode | input | 4 | Waveform generation mode |
| cmp_vals | input | 48 | Compare values, channel A in bits [15:0], B in [31:16], C in [47:32] |
| out_modes | input | 6 | Compare-output modes, 2 bits per channel, A lowest |
| bus_wr | input | 1 | Control byte write strobe |
| bus_wdata | input | 8 | Control byte write data |
| bus_rdata | output | 8 | Control byte read data |
| wave_o | output | 3 | Waveform pins, bit 0 = channel A |
| match_o | output | 3 | One-cycle match flags, bit 0 = channel A |
| cnt_clr_o | output | 1 | Counter clear request to the counter owner |

## Verification
The vector table drives force writes under every compare-output mode, in normal, both clear-on-compare and several PWM modes. It also uses single-channel, all-channel, no-strobe and low-bits-only write bytes. Between them, the vectors separate the channel bit mapping, the mode encoding and the PWM gating. Directed tests use real matches with and without the timer enable, which separates the enable qualifier from plain equality. Force-only cycles show that a force never sets a flag or a clear request. A force that coincides with a toggle match exposes a double toggle. Changing the mode right after a strobe separates sampling at the strobe from later sampling.

// File: rtl/ocf_pkg.sv
package ocf_pkg;
  typedef enum logic [1:0] {
    COM_HOLD = 2'b00,
    COM_FLIP = 2'b01,
    COM_LOW  = 2'b10,
    COM_HIGH = 2'b11
  } com_e;

  localparam logic [3:0] WM_NORMAL  = 4'd0;
  localparam logic [3:0] WM_CTC_A   = 4'd4;
  localparam logic [3:0] WM_CTC_ALT = 4'd12;

  function automatic logic pin_next(input logic cur, input logic [1:0] com);
    case (com_e'(com))
      COM_FLIP: pin_next = ~cur;
      COM_LOW:  pin_next = 1'b0;
      COM_HIGH: pin_next = 1'b1;
      default:  pin_next = cur;
    endcase
  endfunction

  function automatic logic is_nonpwm(input logic [3:0] mode);
    is_nonpwm = (mode == WM_NORMAL) || (mode == WM_CTC_A) || (mode == WM_CTC_ALT);
  endfunction
endpackage

// File: rtl/ocf_strobe_reg.sv
module ocf_strobe_reg #(
  parameter int NCH    = 3,
  parameter int BYTE_W = 8
) (
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              act_en,
  output logic [NCH-1:0]    force_vec,
  output logic [BYTE_W-1:0] rdata
);
  // Strobes occupy the top bits, channel 0 at the MSB.
  for (genvar i = 0; i < NCH; i++) begin : g_bit
    assign force_vec[i] = bus_wr & act_en & bus_wdata[BYTE_W-1-i];
  end
  // Strobes never hold state; reserved bits read as zero.
  assign rdata = '0;
endmodule

// File: rtl/ocf_channel.sv
module ocf_channel
  import ocf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cmp,
  input  logic [1:0]       com,
  input  logic             act_en,
  input  logic             force_i,
  output logic             hit_o,
  output logic             pin_o,
  output logic             flag_o
);
  logic act;

  assign hit_o = tick & (count == cmp);
  assign act   = act_en & (hit_o | force_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_o  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      if (act) pin_o <= pin_next(pin_o, com);
      flag_o <= act_en & hit_o;
    end
  end
endmodule

// File: rtl/ocf_clear_req.sv
module ocf_clear_req
  import ocf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       hit_a,
  input  logic [3:0] mode,
  output logic       clr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           clr_o <= 1'b0;
    else if (hit_a && mode == WM_CTC_A)   clr_o <= 1'b1;
    else if (tick)                        clr_o <= 1'b0;
  end
endmodule

// File: rtl/ocf_wave_unit.sv
module ocf_wave_unit
  import ocf_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NCH    = 3,
  parameter int BYTE_W = 8,
  localparam int CMP_W = CNT_W * NCH,
  localparam int COM_W = 2 * NCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_tick,
  input  logic [CNT_W-1:0]  tmr_count,
  input  logic [3:0]        wave_mode,
  input  logic [CMP_W-1:0]  cmp_vals,
  input  logic [COM_W-1:0]  out_modes,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [NCH-1:0]    wave_o,
  output logic [NCH-1:0]    match_o,
  output logic              cnt_clr_o
);
  logic           act_en;
  logic [NCH-1:0] force_vec;
  logic [NCH-1:0] hit_vec;

  assign act_en = is_nonpwm(wave_mode);

  ocf_strobe_reg #(.NCH(NCH), .BYTE_W(BYTE_W)) u_strobe (
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .act_en   (act_en),
    .force_vec(force_vec),
    .rdata    (bus_rdata)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ocf_channel #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tmr_tick),
      .count  (tmr_count),
      .cmp    (cmp_vals[i*CNT_W +: CNT_W]),
      .com    (out_modes[2*i +: 2]),
      .act_en (act_en),
      .force_i(force_vec[i]),
      .hit_o  (hit_vec[i]),
      .pin_o  (wave_o[i]),
      .flag_o (match_o[i])
    );
  end

  ocf_clear_req u_clr (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tmr_tick),
    .hit_a(hit_vec[0]),
    .mode (wave_mode),
    .clr_o(cnt_clr_o)
  );
endmodule

// File: rtl/ocf_wave_unit_chk.sv
module ocf_wave_unit_chk #(
  parameter int NCH    = 3,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tmr_tick,
  input logic [3:0]        wave_mode,
  input logic [2*NCH-1:0]  out_modes,
  input logic              act_en,
  input logic [NCH-1:0]    force_vec,
  input logic [NCH-1:0]    hit_vec,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic [NCH-1:0]    wave_o,
  input logic [NCH-1:0]    match_o,
  input logic              cnt_clr_o
);
  a_r2_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata == '0);

  a_r5_pwm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |=> $stable(wave_o));

  a_r6_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (force_vec[0] && !hit_vec[0]) |=> !match_o[0]);

  a_r7_force_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (force_vec[0] && !hit_vec[0] && !cnt_clr_o) |=> !cnt_clr_o);

  a_r8_match_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec[0] && act_en) |=> match_o[0]);

  a_r4_set_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_vec[0] || force_vec[0]) && act_en && out_modes[1:0] == 2'b11) |=> wave_o[0]);

  a_r10_clear_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clr_o && !tmr_tick && !(hit_vec[0] && wave_mode == 4'd4)) |=> cnt_clr_o);
endmodule

bind ocf_wave_unit ocf_wave_unit_chk #(.NCH(NCH), .BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tmr_tick (tmr_tick),
  .wave_mode(wave_mode),
  .out_modes(out_modes),
  .act_en   (act_en),
  .force_vec(force_vec),
  .hit_vec  (hit_vec),
  .bus_rdata(bus_rdata),
  .wave_o   (wave_o),
  .match_o  (match_o),
  .cnt_clr_o(cnt_clr_o)
);

// File: tb/tb_ocf_wave_unit.sv
module tb_ocf_wave_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_tick = 1'b0;
  logic [15:0] tmr_count = '0;
  logic [3:0]  wave_mode = '0;
  logic [47:0] cmp_vals = '0;
  logic [5:0]  out_modes = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [2:0]  wave_o;
  logic [2:0]  match_o;
  logic        cnt_clr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ocf_wave_unit dut (.*);

  // {mode, C/B/A out modes, write byte}
  localparam logic [17:0] VEC [16] = '{
    {4'd0,  6'b111111, 8'hE0}, {4'd0,  6'b101010, 8'h80},
    {4'd4,  6'b010101, 8'hE0}, {4'd12, 6'b000000, 8'hE0},
    {4'd1,  6'b101010, 8'hE0}, {4'd14, 6'b010101, 8'hE0},
    {4'd0,  6'b010101, 8'h40}, {4'd0,  6'b010101, 8'h20},
    {4'd0,  6'b011011, 8'hE0}, {4'd4,  6'b111001, 8'h1F},
    {4'd4,  6'b010101, 8'hFF}, {4'd15, 6'b111111, 8'hFF},
    {4'd12, 6'b100111, 8'hC0}, {4'd0,  6'b010101, 8'hA0},
    {4'd7,  6'b010101, 8'hE0}, {4'd0,  6'b101010, 8'hE0}
  };

  function automatic logic m_nonpwm(input logic [3:0] m);
    return m == 4'd0 || m == 4'd4 || m == 4'd12;
  endfunction

  function automatic logic m_pin(input logic cur, input logic [1:0] c);
    if (c == 2'b01) return !cur;
    if (c[1]) return c[0];
    return cur;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    bus_wr = 1'b0;
    tmr_tick = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] exp_pin;
    repeat (3) @(negedge clk);
    check("R1 pins", wave_o, 3'b000);
    check("R1 flags", match_o, 3'b000);
    check("R1 clear", cnt_clr_o, 1'b0);
    check("R2 rdata", bus_rdata, 8'h00);
    rst_n = 1'b1;
    tmr_count = 16'd9999;
    cmp_vals = {16'd300, 16'd200, 16'd100};
    @(negedge clk);
    exp_pin = '0;

    // R3 R4 R5 table walk with force writes
    foreach (VEC[k]) begin
      wave_mode = VEC[k][17:14];
      out_modes = VEC[k][13:8];
      bus_wdata = VEC[k][7:0];
      bus_wr = 1'b1;
      for (int c = 0; c < 3; c++)
        if (m_nonpwm(VEC[k][17:14]) && VEC[k][7-c])
          exp_pin[c] = m_pin(exp_pin[c], VEC[k][8+2*c +: 2]);
      step();
      check("R3/R4/R5 table pins", wave_o, exp_pin);
      check("R6 table flags", match_o, 3'b000);
      check("R2 rdata after write", bus_rdata, 8'h00);
    end

    // R8 real match sets pin A and a one-cycle flag
    wave_mode = 4'd0; out_modes = 6'b101011;
    tmr_count = 16'd100; tmr_tick = 1'b1;
    step();
    check("R8 pin set by match", wave_o[0], 1'b1);
    check("R8 flag raised", match_o, 3'b001);
    step();
    check("R8 flag one cycle", match_o, 3'b000);

    // R9 equal without tick
    out_modes = 6'b000001;
    step();
    check("R9 no flag", match_o, 3'b000);
    check("R9 pin held", wave_o[0], 1'b1);

    // R6 force alone in normal mode
    bus_wdata = 8'h80; bus_wr = 1'b1; tmr_count = 16'd5;
    step();
    check("R6 force toggles A", wave_o[0], 1'b0);
    check("R6 no flag", match_o, 3'b000);

    // R11 force plus match toggles once
    bus_wdata = 8'h80; bus_wr = 1'b1; tmr_count = 16'd100; tmr_tick = 1'b1;
    step();
    check("R11 single toggle", wave_o[0], 1'b1);
    check("R11 flag", match_o[0], 1'b1);

    // R10 no request in mode 0 after that match
    check("R10 no clear in normal mode", cnt_clr_o, 1'b0);

    // R7 force in clear-on-compare mode
    wave_mode = 4'd4; bus_wdata = 8'hE0; bus_wr = 1'b1; tmr_count = 16'd7;
    step();
    step();
    check("R7 force no clear", cnt_clr_o, 1'b0);

    // R10 real match A in mode 4
    tmr_count = 16'd100; tmr_tick = 1'b1;
    step();
    check("R10 clear raised", cnt_clr_o, 1'b1);
    step();
    check("R10 clear held without tick", cnt_clr_o, 1'b1);
    tmr_count = 16'd0; tmr_tick = 1'b1;
    step();
    check("R10 clear dropped on tick", cnt_clr_o, 1'b0);

    // R12 mode sampled at strobe
    wave_mode = 4'd0; out_modes = 6'b000011; bus_wdata = 8'h80; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; out_modes = 6'b000010;
    check("R12 set at strobe", wave_o[0], 1'b1);
    step();
    check("R12 later mode no effect", wave_o[0], 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule